// File: doc/BRIEF.md
# LIN Break Generator and Detector

This block adds break handling to a UART running in LIN mode. On the transmit side, a break request overrides the UART's serial output. The block drives thirteen bit times of dominant low, then one recessive high delimiter bit, and then hands the line back to the UART. On the receive side, a detector watches the RX line on its own, apart from the normal receiver. It reports a break whenever one occurs, whether the line was idle or a frame was in progress.

Both halves are timed by a one-cycle bit tick supplied by the UART's baud generator. The detector arms on a falling edge of RX, counts low samples taken on the bit tick, and declares a break after eleven consecutive lows. A declared break sets a sticky flag that the host clears. An interrupt output follows the flag when its enable is set. After a declaration the detector waits for the line to go high before it arms again.

Top module: `lin_break_unit`

## Requirements
- R1: Out of reset the block is idle: `brk_busy`, `brk_flag` and `brk_irq` are 0, and `tx_line` equals `tx_uart`.
- R2: A break request (`brk_req` high for a cycle) is accepted only when `lin_en` is 1, `tx_idle` is 1 and no break is in progress. Otherwise it is ignored: `brk_busy` stays 0 and `tx_line` keeps following `tx_uart`.
- R3: An accepted break holds `tx_line` at 0 for exactly 13 bit ticks, counted from acceptance.
- R4: After the low phase, `tx_line` is driven to 1 for exactly one bit tick. `brk_busy` then returns to 0 on its own.
- R5: Whenever no break is in progress, `tx_line` equals `tx_uart`.
- R6: The detector can declare a break only while both `lin_en` and `rx_en` are 1.
- R7: A detection starts only on a high-to-low transition of `rx_line`. A break is declared at the 11th consecutive low sample taken on `bit_tick`. A high sample taken earlier abandons the attempt, so a low run of 10 ticks sets no flag. A line that is already low when the detector is enabled sets no flag.
- R8: Detection also works when a break begins in the middle of a character, and an ordinary all-zero character (9 low bits) is not reported.
- R9: After a break is declared, no further break is reported until `rx_line` has returned to 1, however long the line stays low.
- R10: `brk_flag` is sticky. It stays at 1 until `brk_clr` is pulsed, and a new declaration in the same cycle as a clear takes precedence.
- R11: `brk_irq` is 1 exactly when `brk_flag` is 1 and `brk_irq_en` is 1.
- R12: Dropping `lin_en` during a break ends it at once. `brk_busy` returns to 0 and `tx_line` follows `tx_uart` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lin_en | input | 1 | LIN mode enable; gates both generator and detector |
| rx_en | input | 1 | Receiver enable; arms the detector |
| tx_idle | input | 1 | UART transmitter has nothing in flight |
| brk_req | input | 1 | Send-break request pulse |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| tx_uart | input | 1 | Serial output of the normal UART transmitter |
| rx_line | input | 1 | Synchronised RX line |
| brk_clr | input | 1 | Clears the break-detected flag |
| brk_irq_en | input | 1 | Interrupt enable for break detection |
| tx_line | output | 1 | Serial line toward the pin |
| brk_busy | output | 1 | Break or delimiter in progress |
| brk_flag | output | 1 | Sticky break-detected flag |
| brk_irq | output | 1 | Break-detected interrupt |

## Verification
The bench sweeps low-run lengths from 1 to 14 bit ticks. This catches an off-by-one threshold, which would flag a 10-tick run or miss an 11-tick one. It also drives a break that starts mid-character and an all-zero character. A detector that counted without an edge, or that did not reset on a high sample, would misreport one of these. The bench holds the line low for twenty ticks past a declaration and clears the flag during that time. A detector that re-armed early would set the flag again. On the transmit side, the bench counts the low and delimiter ticks on `tx_line` and offers requests while the transmitter is busy or LIN mode is off. It also withdraws LIN mode in mid-break. A wrong counter, a missing delimiter or a stuck override would show up directly on the line.

// File: rtl/lin_break_pkg.sv
package lin_break_pkg;

  typedef enum logic [1:0] {
    GEN_IDLE  = 2'd0,
    GEN_LOW   = 2'd1,
    GEN_DELIM = 2'd2
  } gen_state_e;

  typedef enum logic [1:0] {
    DET_ARM   = 2'd0,
    DET_COUNT = 2'd1,
    DET_WAIT  = 2'd2
  } det_state_e;

endpackage

// File: rtl/lin_brk_gen.sv
module lin_brk_gen
  import lin_break_pkg::*;
#(
  parameter int LOW_BITS = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lin_en,
  input  logic tx_idle,
  input  logic brk_req,
  input  logic bit_tick,
  input  logic tx_uart,
  output logic tx_line,
  output logic busy
);

  localparam int CW = $clog2(LOW_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(LOW_BITS - 1);

  gen_state_e      st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;

  // next-state
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!lin_en) begin
      st_d  = GEN_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        GEN_IDLE: begin
          if (brk_req && tx_idle) begin
            st_d  = GEN_LOW;
            cnt_d = '0;
          end
        end
        GEN_LOW: begin
          if (bit_tick) begin
            if (cnt_q == LAST) begin
              st_d  = GEN_DELIM;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        GEN_DELIM: begin
          if (bit_tick) st_d = GEN_IDLE;
        end
        default: begin
          st_d  = GEN_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= GEN_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    unique case (st_q)
      GEN_LOW:   tx_line = 1'b0;
      GEN_DELIM: tx_line = 1'b1;
      default:   tx_line = tx_uart;
    endcase
  end

  assign busy = (st_q != GEN_IDLE);

  // R2: a break starts only from an accepted request
  assert_accept_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(brk_req && tx_idle && lin_en));

  // R4: the break always ends on a high delimiter unless aborted
  assert_delim_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(lin_en)) |-> $past(tx_line));

  // R12: withdrawing LIN mode ends the break on the next edge
  assert_abort_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !lin_en |=> !busy);

endmodule

// File: rtl/lin_brk_det.sv
module lin_brk_det
  import lin_break_pkg::*;
#(
  parameter int LOW_SAMPLES = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lin_en,
  input  logic rx_en,
  input  logic bit_tick,
  input  logic rx_line,
  output logic det_pulse
);

  localparam int CW = $clog2(LOW_SAMPLES + 1);
  localparam logic [CW-1:0] LAST = CW'(LOW_SAMPLES - 1);

  det_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rx_q;
  logic          armed;
  logic          fall;

  assign armed = lin_en && rx_en;
  assign fall  = rx_q && !rx_line;

  // next-state
  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    det_pulse = 1'b0;
    if (!armed) begin
      st_d  = DET_ARM;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        DET_ARM: begin
          if (fall) begin
            st_d  = DET_COUNT;
            cnt_d = '0;
          end
        end
        DET_COUNT: begin
          if (bit_tick) begin
            if (rx_line) begin
              st_d = DET_ARM;
            end else if (cnt_q == LAST) begin
              st_d      = DET_WAIT;
              det_pulse = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        DET_WAIT: begin
          if (rx_line) st_d = DET_ARM;
        end
        default: st_d = DET_ARM;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= DET_ARM;
      cnt_q <= '0;
      rx_q  <= 1'b1;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      rx_q  <= rx_line;
    end
  end

  // R7: a break is only declared on a low sample taken on a tick
  assert_declare_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    det_pulse |-> (!rx_line && bit_tick));

  // R6: no declaration while disarmed
  assert_armed_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    det_pulse |-> (lin_en && rx_en));

  // R9: after a declaration, a low line cannot produce another one next cycle
  assert_no_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (det_pulse && !rx_line) |=> !det_pulse);

endmodule

// File: rtl/lin_break_unit.sv
module lin_break_unit #(
  parameter int BRK_LOW_BITS = 13,
  parameter int DET_LOW_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lin_en,
  input  logic rx_en,
  input  logic tx_idle,
  input  logic brk_req,
  input  logic bit_tick,
  input  logic tx_uart,
  input  logic rx_line,
  input  logic brk_clr,
  input  logic brk_irq_en,
  output logic tx_line,
  output logic brk_busy,
  output logic brk_flag,
  output logic brk_irq
);

  logic det_pulse;
  logic flag_d;
  logic flag_q;

  lin_brk_gen #(.LOW_BITS(BRK_LOW_BITS)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .lin_en   (lin_en),
    .tx_idle  (tx_idle),
    .brk_req  (brk_req),
    .bit_tick (bit_tick),
    .tx_uart  (tx_uart),
    .tx_line  (tx_line),
    .busy     (brk_busy)
  );

  lin_brk_det #(.LOW_SAMPLES(DET_LOW_BITS)) u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .lin_en    (lin_en),
    .rx_en     (rx_en),
    .bit_tick  (bit_tick),
    .rx_line   (rx_line),
    .det_pulse (det_pulse)
  );

  // next-state of the sticky flag: a new declaration wins over a clear
  always_comb begin
    flag_d = flag_q;
    if (det_pulse)    flag_d = 1'b1;
    else if (brk_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign brk_flag = flag_q;
  assign brk_irq  = flag_q && brk_irq_en;

  // R10: the flag holds until a clear arrives
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_flag && !brk_clr) |=> brk_flag);

  // R10: the flag only rises after an armed detector saw a low line
  assert_flag_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_flag) |-> $past(lin_en && rx_en && !rx_line));

endmodule

// File: tb/test_lin_break_unit.sv
module test_lin_break_unit;

  logic clk = 1'b0;
  logic rst_n;
  logic lin_en, rx_en, tx_idle, brk_req, tx_uart, rx_line, brk_clr, brk_irq_en;
  logic tx_line, brk_busy, brk_flag, brk_irq;
  logic bit_tick;
  logic [1:0] tcnt;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  // bit tick every 4 cycles, updated on the rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tcnt <= 2'd0;
    else        tcnt <= tcnt + 2'd1;
  end
  assign bit_tick = (tcnt == 2'd3);

  lin_break_unit i_lin_break_unit (
    .clk(clk), .rst_n(rst_n), .lin_en(lin_en), .rx_en(rx_en), .tx_idle(tx_idle),
    .brk_req(brk_req), .bit_tick(bit_tick), .tx_uart(tx_uart), .rx_line(rx_line),
    .brk_clr(brk_clr), .brk_irq_en(brk_irq_en), .tx_line(tx_line),
    .brk_busy(brk_busy), .brk_flag(brk_flag), .brk_irq(brk_irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // returns at the falling edge just after a tick has been consumed
  task automatic wait_tick();
    @(negedge clk);
    while (!bit_tick) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic hold_rx(input logic v, input int n);
    rx_line = v;
    for (int i = 0; i < n; i++) wait_tick();
  endtask

  task automatic clear_flag();
    brk_clr = 1'b1;
    @(negedge clk);
    brk_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_break(output int lows, output int delims, output bit started);
    lows = 0; delims = 0; started = 0;
    wait_tick();
    brk_req = 1'b1;
    @(negedge clk);
    brk_req = 1'b0;
    started = brk_busy;
    for (int c = 0; c < 200 && brk_busy; c++) begin
      if (bit_tick && !tx_line) lows++;
      if (bit_tick && tx_line) delims++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int lows, delims;
    bit started;
    rst_n = 1'b0; lin_en = 1'b0; rx_en = 1'b0; tx_idle = 1'b1; brk_req = 1'b0;
    tx_uart = 1'b1; rx_line = 1'b1; brk_clr = 1'b0; brk_irq_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(brk_busy == 0, "R1 busy", brk_busy, 0);
    chk(brk_flag == 0, "R1 flag", brk_flag, 0);
    chk(brk_irq == 0, "R1 irq", brk_irq, 0);
    chk(tx_line == 1, "R1 tx", tx_line, 1);
    tx_uart = 1'b0;
    @(negedge clk);
    chk(tx_line == 0, "R5 passthrough", tx_line, 0);
    tx_uart = 1'b1;

    lin_en = 1'b1; rx_en = 1'b1;
    // R7 sweep of low-run lengths
    for (int len = 1; len <= 14; len++) begin
      hold_rx(1'b1, 2);
      hold_rx(1'b0, len);
      hold_rx(1'b1, 1);
      chk(brk_flag == (len >= 11), $sformatf("R7 len=%0d", len), brk_flag, len >= 11);
      if (len >= 11) begin
        chk(brk_irq == 0, "R11 irq gated", brk_irq, 0);
        hold_rx(1'b1, 3);
        chk(brk_flag == 1, "R10 sticky", brk_flag, 1);
        brk_irq_en = 1'b1;
        @(negedge clk);
        chk(brk_irq == 1, "R11 irq on", brk_irq, 1);
        brk_irq_en = 1'b0;
        clear_flag();
        chk(brk_flag == 0, "R10 cleared", brk_flag, 0);
      end
    end

    // R9 no re-arm while low
    hold_rx(1'b1, 2);
    hold_rx(1'b0, 11);
    chk(brk_flag == 1, "R9 first", brk_flag, 1);
    clear_flag();
    hold_rx(1'b0, 20);
    chk(brk_flag == 0, "R9 no rearm", brk_flag, 0);
    hold_rx(1'b1, 1);
    hold_rx(1'b0, 11);
    hold_rx(1'b1, 1);
    chk(brk_flag == 1, "R9 rearmed", brk_flag, 1);
    clear_flag();

    // R8 all-zero character then mid-character break
    hold_rx(1'b1, 2);
    hold_rx(1'b0, 9);
    hold_rx(1'b1, 2);
    chk(brk_flag == 0, "R8 zero char", brk_flag, 0);
    hold_rx(1'b0, 1);
    hold_rx(1'b1, 1);
    hold_rx(1'b0, 1);
    hold_rx(1'b1, 2);
    hold_rx(1'b0, 11);
    hold_rx(1'b1, 1);
    chk(brk_flag == 1, "R8 mid frame", brk_flag, 1);
    clear_flag();

    // R6 disarmed detector
    rx_en = 1'b0;
    hold_rx(1'b1, 1);
    hold_rx(1'b0, 14);
    hold_rx(1'b1, 1);
    chk(brk_flag == 0, "R6 rx_en off", brk_flag, 0);
    rx_en = 1'b1; lin_en = 1'b0;
    hold_rx(1'b0, 14);
    hold_rx(1'b1, 1);
    chk(brk_flag == 0, "R6 lin off", brk_flag, 0);
    lin_en = 1'b1;

    // R7 already low when enabled: no edge, no flag
    rx_en = 1'b0;
    hold_rx(1'b0, 1);
    rx_en = 1'b1;
    hold_rx(1'b0, 14);
    hold_rx(1'b1, 1);
    chk(brk_flag == 0, "R7 no edge", brk_flag, 0);

    // R3 R4 generator with both levels of tx_uart
    for (int v = 0; v < 2; v++) begin
      tx_uart = v[0];
      run_break(lows, delims, started);
      chk(started == 1, "R2 accepted", started, 1);
      chk(lows == 13, "R3 low ticks", lows, 13);
      chk(delims == 1, "R4 delimiter", delims, 1);
      chk(brk_busy == 0, "R4 busy drop", brk_busy, 0);
      chk(tx_line == v[0], "R5 after break", tx_line, v);
    end

    // R2 refused requests
    tx_uart = 1'b1;
    tx_idle = 1'b0;
    run_break(lows, delims, started);
    chk(started == 0, "R2 tx busy", started, 0);
    tx_idle = 1'b1; lin_en = 1'b0;
    run_break(lows, delims, started);
    chk(started == 0, "R2 lin off", started, 0);
    chk(tx_line == 1, "R2 tx follows", tx_line, 1);
    lin_en = 1'b1;

    // R12 abort
    wait_tick();
    brk_req = 1'b1;
    @(negedge clk);
    brk_req = 1'b0;
    wait_tick(); wait_tick(); wait_tick();
    chk(tx_line == 0, "R12 in break", tx_line, 0);
    lin_en = 1'b0;
    @(negedge clk);
    chk(brk_busy == 0, "R12 busy", brk_busy, 0);
    chk(tx_line == 1, "R12 tx", tx_line, 1);

    summary();
  end

endmodule